// File: doc/BRIEF.md
# Windowed Coefficient-Bank Multiply-Accumulate Tap

This block is one tap of a filter datapath. On every clock it multiplies a registered signed 8-bit pixel by a signed 12-bit fractional coefficient. The coefficient comes from a row of a small writable coefficient bank. A registered 8-bit address picks the row, and that address only changes while its active-low enable is asserted. The product is scaled to the accumulator's fixed-point grid and summed into a signed 32-bit accumulator. A sum-start control instead loads the accumulator with the current product, which begins a new sum.

The output is not a fixed truncation of the accumulator. A 5-bit window code picks which 16 consecutive accumulator bits appear on the registered output. The same tap can therefore serve filters of different gain and precision without extra rounding logic. The bank is loaded through a plain synchronous write port. Rows reset to zero.

Top module: `tap_mac_window`

## Requirements
- R1: The pixel input is 8-bit two's complement with integer weights (-128..127). It is registered on the rising edge, and the product uses this registered value.
- R2: A coefficient is a 12-bit two's complement fraction, with bit 11 weighted -1 and bit 0 weighted 2^-11. The accumulator LSB is weighted 2^-15, so each product enters the accumulator shifted left by 4 bits and sign-extended to 32 bits. Accumulator bits 3..0 therefore stay zero.
- R3: The coefficient row address is captured on a rising edge only when `cf_addr_en_n` is 0. When it is 1, the address held earlier keeps selecting the row.
- R4: Window code w in 0..16 puts accumulator bits w+15..w on `res_out`. Code 0 gives bits 15..0 and code 16 gives bits 31..16. The code is sampled at the edge that loads `res_out`.
- R5: Window codes 17 through 31 behave exactly as code 16.
- R6: When `sum_start` is 1 at an edge, the accumulator is loaded with the product of that vector one edge later. When it is 0, the product is added to the running sum.
- R7: The accumulator wraps modulo 2^32 on overflow. It has no saturation.
- R8: While `rst_n` is 0, the accumulator, the output, the input registers and every bank row are cleared to zero.
- R9: A bank write (`bank_we` = 1) updates row `bank_waddr` at the edge. A product that uses that row on a later edge sees the new value. A product computed at the same edge still sees the old value.
- R10: Latency is two edges. A vector driven before edge t contributes to the accumulator at edge t+1, and `res_out` reflects it at edge t+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in | input | 8 | Signed pixel sample |
| cf_addr | input | 8 | Coefficient row address |
| cf_addr_en_n | input | 1 | Active-low capture enable for cf_addr |
| sum_start | input | 1 | Load the product instead of adding it |
| win_sel | input | 5 | Output window code |
| bank_we | input | 1 | Coefficient bank write strobe |
| bank_waddr | input | 8 | Row written by bank_we |
| bank_wdata | input | 12 | Signed fractional coefficient to write |
| res_out | output | 16 | Registered windowed accumulator slice |

## Verification
A wrong row address or a wrongly held address gives a product of the wrong coefficient. That error reaches `res_out` two edges later and stays in every following sum until the next sum start. A misaligned product or a wrong sign extension corrupts the low window codes at once, and the high codes once values grow or go negative. A window mux error shows only for the codes that are mis-decoded, so all 32 codes are exercised. A long accumulation checks the wrap at the top window.

// File: rtl/tap_mac_window.sv
module tap_mac_window #(
  parameter int DW      = 8,
  parameter int CW      = 12,
  parameter int AW      = 8,
  parameter int ACCW    = 32,
  parameter int OW      = 16,
  parameter int SELW    = 5,
  parameter int CF_FRAC = 11,
  parameter int AC_FRAC = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   pix_in,
  input  logic [AW-1:0]   cf_addr,
  input  logic            cf_addr_en_n,
  input  logic            sum_start,
  input  logic [SELW-1:0] win_sel,
  input  logic            bank_we,
  input  logic [AW-1:0]   bank_waddr,
  input  logic [CW-1:0]   bank_wdata,
  output logic [OW-1:0]   res_out
);
  localparam int ROWS   = 1 << AW;
  localparam int PW     = DW + CW;
  localparam int SH     = AC_FRAC - CF_FRAC;
  localparam int EXT    = ACCW - PW - SH;
  localparam int MAXSEL = ACCW - OW;

  logic [CW-1:0]   bank [ROWS];
  logic [DW-1:0]   pix_q;
  logic [AW-1:0]   addr_q;
  logic            clr_q;
  logic [ACCW-1:0] acc;
  logic [PW-1:0]   prod;
  logic [ACCW-1:0] prod_ext;
  logic [SELW-1:0] sel_eff;
  logic [ACCW-1:0] shifted;

  assign prod     = PW'($signed(pix_q) * $signed(bank[addr_q]));
  assign prod_ext = {{EXT{prod[PW-1]}}, prod, {SH{1'b0}}};
  assign sel_eff  = (int'(win_sel) > MAXSEL) ? SELW'(MAXSEL) : win_sel;
  assign shifted  = acc >> sel_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) bank[i] <= '0;
    end else if (bank_we) begin
      bank[bank_waddr] <= bank_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q   <= '0;
      addr_q  <= '0;
      clr_q   <= 1'b0;
      acc     <= '0;
      res_out <= '0;
    end else begin
      pix_q   <= pix_in;
      clr_q   <= sum_start;
      if (!cf_addr_en_n) addr_q <= cf_addr;
      acc     <= clr_q ? prod_ext : acc + prod_ext;
      res_out <= shifted[OW-1:0];
    end
  end
endmodule

module tap_mac_window_chk #(
  parameter int AW = 8, parameter int ACCW = 32, parameter int OW = 16, parameter int SELW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   cf_addr,
  input logic            cf_addr_en_n,
  input logic [SELW-1:0] win_sel,
  input logic [AW-1:0]   addr_q,
  input logic            clr_q,
  input logic [ACCW-1:0] prod_ext,
  input logic [ACCW-1:0] acc,
  input logic [OW-1:0]   res_out
);
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cf_addr_en_n |=> $stable(addr_q)); // R3
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cf_addr_en_n |=> addr_q == $past(cf_addr)); // R3
  AST_ACC_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc[3:0] == 4'b0); // R2
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> acc == $past(prod_ext)); // R6
  AST_WIN_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel == '0 |=> res_out == $past(acc[OW-1:0])); // R4
  AST_WIN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_sel) >= ACCW - OW |=> res_out == $past(acc[ACCW-1:ACCW-OW])); // R5
endmodule

bind tap_mac_window tap_mac_window_chk #(.AW(AW), .ACCW(ACCW), .OW(OW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cf_addr(cf_addr), .cf_addr_en_n(cf_addr_en_n),
  .win_sel(win_sel), .addr_q(addr_q), .clr_q(clr_q), .prod_ext(prod_ext),
  .acc(acc), .res_out(res_out)
);

// File: tb/tb_tap_mac_window.sv
`timescale 1ns/1ps
module tb_tap_mac_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pix_in = '0;
  logic [7:0]  cf_addr = '0;
  logic        cf_addr_en_n = 1'b1;
  logic        sum_start = 1'b0;
  logic [4:0]  win_sel = '0;
  logic        bank_we = 1'b0;
  logic [7:0]  bank_waddr = '0;
  logic [11:0] bank_wdata = '0;
  logic [15:0] res_out;

  always #2.5 clk = ~clk;

  tap_mac_window dut (.*);

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] m_bank [256];
  logic [7:0]  m_pix = '0, m_addr = '0;
  logic        m_clr = 1'b0;
  logic [31:0] m_acc = '0;
  bit          done = 0;

  function automatic logic [31:0] scaled(logic [7:0] p, logic [11:0] c);
    logic signed [31:0] v;
    v = $signed(p) * $signed(c);
    return v * 16;
  endfunction

  function automatic logic [15:0] win(logic [31:0] a, logic [4:0] s);
    int e;
    e = (s > 16) ? 16 : int'(s);
    return a[e +: 16];
  endfunction

  task automatic step(input logic [7:0] p, input logic [7:0] a, input logic en_n,
                      input logic st, input logic [4:0] s, input logic we,
                      input logic [7:0] wa, input logic [11:0] wd, input string tag);
    logic [15:0] e;
    logic [31:0] pr;
    pix_in = p; cf_addr = a; cf_addr_en_n = en_n; sum_start = st; win_sel = s;
    bank_we = we; bank_waddr = wa; bank_wdata = wd;
    e  = win(m_acc, s);
    pr = scaled(m_pix, m_bank[m_addr]);
    m_acc = m_clr ? pr : m_acc + pr;
    if (we) m_bank[wa] = wd;
    m_pix = p; m_clr = st;
    if (!en_n) m_addr = a;
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (res_out !== e) begin
        fails++;
        $display("FAIL %s: res_out=%h expected=%h", t, res_out, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_bank[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_out !== 16'h0) begin
      fails++;
      $display("FAIL R8: res_out=%h expected=0000", res_out);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R9: load bank rows
    step(0, 0, 1, 1, 0, 1, 3,   12'h400, "R9");
    step(0, 0, 1, 1, 0, 1, 7,   12'h800, "R9");
    step(0, 0, 1, 1, 0, 1, 200, 12'h7FF, "R9");
    step(0, 0, 1, 1, 0, 1, 255, 12'h001, "R9");
    // R1 R2 R6 R10: single product, viewed through several windows
    step(8'd100, 3, 0, 1, 0, 0, 0, 0, "R6");
    for (int s = 0; s < 20; s++) step(0, 3, 1, 1, 5'(s), 0, 0, 0, "R4");
    step(8'sd127, 200, 0, 1, 0, 0, 0, 0, "R1");
    for (int s = 0; s < 17; s++) step(8'sd127, 200, 1, 0, 5'(s), 0, 0, 0, "R2");
    step(8'h80, 255, 0, 1, 0, 0, 0, 0, "R2");
    step(0, 255, 1, 1, 0, 0, 0, 0, "R2");
    step(0, 255, 1, 1, 12, 0, 0, 0, "R2");
    // R3: address changes ignored while enable is high
    step(8'd50, 7, 0, 1, 4, 0, 0, 0, "R3");
    for (int k = 0; k < 6; k++) step(8'd50, 8'(k * 40 + 1), 1, 0, 4, 0, 0, 0, "R3");
    // R5: codes above 16
    for (int s = 16; s < 32; s++) step(0, 7, 1, 0, 5'(s), 0, 0, 0, "R5");
    // R9: write into the row in use
    step(8'd10, 3, 0, 1, 0, 0, 0, 0, "R9");
    step(8'd10, 3, 1, 1, 0, 1, 3, 12'h7FF, "R9");
    step(8'd10, 3, 1, 1, 0, 0, 0, 0, "R9");
    step(8'd10, 3, 1, 1, 4, 0, 0, 0, "R9");
    step(8'd10, 3, 1, 1, 8, 0, 0, 0, "R9");
    // R7: long accumulation of the largest product wraps
    step(8'h80, 7, 0, 1, 16, 0, 0, 0, "R7");
    for (int k = 0; k < 1100; k++) step(8'h80, 7, 1, 0, 16, 0, 0, 0, "R7");
    // mixed traffic
    for (int k = 0; k < 400; k++)
      step(8'($urandom), 8'($urandom), 1'($urandom), ($urandom % 8) == 0, 5'($urandom),
           ($urandom % 5) == 0, 8'($urandom), 12'($urandom), "R10");
    step(0, 0, 1, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 1, 0, 0, 0, 0, 0, "R10");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule